// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronisation Unit

This block turns a system clock into the bit-level timing of a CAN node. A programmable divider produces the time-quantum tick. A segment sequencer walks each bit through a one-quantum synchronisation slot, a propagation slot and two phase slots. It raises a sample strobe where the receive bit should be read and a transmit strobe where the next bit may be launched. When the receive line falls from recessive (1) to dominant (0), the sequencer realigns itself. While the bus is idle it restarts the bit outright. Otherwise it stretches phase 1 or trims phase 2 by no more than the programmed jump width.

A single configuration word sets all timing lengths, each stored as the length minus one. The timing fields accept a write only while `freeze` is high, and the sequencer and divider stay parked while frozen. Two interrupt-enable bits in the same word gate the bus-off and error event inputs onto the interrupt outputs. These two bits can be written at any time.

Configuration word layout (bit positions): [2:0] propagation length−1, [5:3] phase-1 length−1, [8:6] phase-2 length−1, [10:9] jump width−1, [18:11] divider value, [19] error interrupt enable, [20] bus-off interrupt enable, the rest reads 0.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the configuration readback is 0x40: the phase-2 field is 1 and every other field is 0. No strobe and no interrupt output is active.
- R2: Outside freeze, `tq_tick` is high for one clock in every (divider+1) clocks, giving exactly 2·N ticks over two bits of N quanta.
- R3: A bit lasts N = 1 + (prop+1) + (ph1+1) + (ph2+1) quanta. Counting quanta from 0 at the sync slot, `sample_stb` pulses with the tick that ends quantum (prop+1)+(ph1+1) and `tx_stb` pulses with the tick that ends quantum N−1. Both are single-clock pulses.
- R4: While `freeze` is high, `tq_tick`, `sample_stb` and `tx_stb` stay low. After `freeze` falls, the first bit starts at its sync quantum in the first unfrozen clock.
- R5: A write with `freeze` low leaves the divider, propagation, phase and jump-width fields (bits [18:0]) unchanged.
- R6: Writing 0 into the phase-2 field stores 1.
- R7: A falling edge on the synchronised `rx` while `bus_idle` is high restarts the bit. The clock after the edge is detected is sync quantum 0, and no strobe fires in the detecting clock.
- R8: A soft-resync falling edge in the propagation slot or in phase 1, at quantum position p of the bit, lengthens phase 1 by min(p, jump width+1) quanta.
- R9: A soft-resync falling edge in phase 2, with r quanta of phase 2 remaining (current one included), shortens phase 2 by min(r, jump width+1) quanta.
- R10: At most one soft resynchronisation takes effect per bit. A second falling edge in the same bit leaves the timing as the first edge left it.
- R11: `busoff_irq` equals `busoff_evt` AND bit 20, and `err_irq` equals `err_evt` AND bit 19. These enable bits take a write whether or not the unit is frozen.
- R12: A falling edge seen during the sync quantum, and any rising edge on `rx`, leave the bit timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Parks the timing and opens the timing fields to writes |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Configuration readback |
| rx | input | 1 | Receive line, recessive = 1 |
| bus_idle | input | 1 | High when frame logic sees the bus idle (hard resync) |
| busoff_evt | input | 1 | Bus-off event from the error logic |
| err_evt | input | 1 | Error event from the error logic |
| tq_tick | output | 1 | Time-quantum tick |
| sample_stb | output | 1 | Sample-point strobe |
| tx_stb | output | 1 | Transmit-point strobe (bit boundary) |
| busoff_irq | output | 1 | Gated bus-off interrupt |
| err_irq | output | 1 | Gated error interrupt |

## Verification
A corrupt segment counter or limit register moves `sample_stb` and `tx_stb` off their computed clock positions within the same bit. The bench therefore measures strobe positions to the clock across two or three bits. A resync error, such as a missing jump-width cap, a second adjustment in one bit, or a wrong remaining-quanta count, shows as a strobe one or more quanta early or late in the bit that holds the edge. It also shows as a fixed offset on every later strobe. Divider faults change the tick count over the window at once, and a leaky freeze gate shows on the readback the clock after the write.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } seg_e;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
   parameter int PRESC_W = 8,
   parameter int SEG_W   = 3,
   parameter int SJW_W   = 2,
   parameter int CFG_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               freeze,
   input  logic               wr_en,
   input  logic [CFG_W-1:0]   wdata,
   output logic [CFG_W-1:0]   rdata,
   output logic [PRESC_W-1:0] presc,
   output logic [SEG_W-1:0]   prop,
   output logic [SEG_W-1:0]   ph1,
   output logic [SEG_W-1:0]   ph2,
   output logic [SJW_W-1:0]   sjw,
   output logic               err_en,
   output logic               boff_en
);
   localparam int OFS_PROP = 0;
   localparam int OFS_PH1  = SEG_W;
   localparam int OFS_PH2  = 2 * SEG_W;
   localparam int OFS_SJW  = 3 * SEG_W;
   localparam int OFS_PRE  = OFS_SJW + SJW_W;
   localparam int OFS_ERR  = OFS_PRE + PRESC_W;
   localparam int OFS_BOFF = OFS_ERR + 1;

   logic [SEG_W-1:0] ph2_wr;
   assign ph2_wr = (wdata[OFS_PH2 +: SEG_W] == '0) ? SEG_W'(1) : wdata[OFS_PH2 +: SEG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc   <= '0;
         prop    <= '0;
         ph1     <= '0;
         ph2     <= SEG_W'(1);
         sjw     <= '0;
         err_en  <= 1'b0;
         boff_en <= 1'b0;
      end else if (wr_en) begin
         err_en  <= wdata[OFS_ERR];
         boff_en <= wdata[OFS_BOFF];
         if (freeze) begin
            presc <= wdata[OFS_PRE  +: PRESC_W];
            prop  <= wdata[OFS_PROP +: SEG_W];
            ph1   <= wdata[OFS_PH1  +: SEG_W];
            ph2   <= ph2_wr;
            sjw   <= wdata[OFS_SJW  +: SJW_W];
         end
      end
   end

   always_comb begin
      rdata                      = '0;
      rdata[OFS_PROP +: SEG_W]   = prop;
      rdata[OFS_PH1  +: SEG_W]   = ph1;
      rdata[OFS_PH2  +: SEG_W]   = ph2;
      rdata[OFS_SJW  +: SJW_W]   = sjw;
      rdata[OFS_PRE  +: PRESC_W] = presc;
      rdata[OFS_ERR]             = err_en;
      rdata[OFS_BOFF]            = boff_en;
   end

   assert_timing_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !freeze |=> $stable({presc, prop, ph1, ph2, sjw}));
   assert_ph2_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ph2 != '0);
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic               restart,
   input  logic [PRESC_W-1:0] div,
   output logic               tick
);
   logic [PRESC_W-1:0] cnt_q;

   assign tick = !hold && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (hold || restart || tick)  cnt_q <= '0;
      else                               cnt_q <= cnt_q + PRESC_W'(1);
   end

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= div);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
   import can_bt_pkg::*;
#(
   parameter int SEG_W       = 3,
   parameter int SJW_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             tick,
   input  logic             rx,
   input  logic             bus_idle,
   input  logic [SEG_W-1:0] prop,
   input  logic [SEG_W-1:0] ph1,
   input  logic [SEG_W-1:0] ph2,
   input  logic [SJW_W-1:0] sjw,
   output logic             restart,
   output logic             sample_stb,
   output logic             tx_stb
);
   localparam int QW = SEG_W + 3;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_prev_q;
   logic                   rx_s;
   logic                   fall;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= rx;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= sync_q[g-1];
      end
   end

   assign rx_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) rx_prev_q <= 1'b1;
      else        rx_prev_q <= rx_s;

   assign fall = rx_prev_q && !rx_s;

   seg_e          seg_q;
   logic [QW-1:0] qcnt_q, lim1_q, lim2_q;
   logic          rs_done_q;

   logic [QW-1:0] prop_len, base1, base2, sjw_len, pos, ext, err2, shrink;
   logic [QW-1:0] lim1_n, lim2_n, qnext;
   logic          hard_go, late_go, early_go, seg_end;

   always_comb begin
      prop_len = QW'(prop) + QW'(1);
      base1    = QW'(ph1)  + QW'(1);
      base2    = QW'(ph2)  + QW'(1);
      sjw_len  = QW'(sjw)  + QW'(1);
      qnext    = qcnt_q + QW'(1);
      unique case (seg_q)
         SEG_PROP: pos = qnext;
         SEG_PH1:  pos = qnext + prop_len;
         default:  pos = '0;
      endcase
      ext      = (pos < sjw_len) ? pos : sjw_len;
      err2     = lim2_q - qcnt_q;
      shrink   = (err2 < sjw_len) ? err2 : sjw_len;
      hard_go  = fall && bus_idle && !hold;
      late_go  = fall && !bus_idle && !hold && !rs_done_q &&
                 (seg_q == SEG_PROP || seg_q == SEG_PH1);
      early_go = fall && !bus_idle && !hold && !rs_done_q && (seg_q == SEG_PH2);
      lim1_n   = late_go  ? base1 + ext      : lim1_q;
      lim2_n   = early_go ? lim2_q - shrink  : lim2_q;
      unique case (seg_q)
         SEG_SYNC: seg_end = 1'b1;
         SEG_PROP: seg_end = qnext >= prop_len;
         SEG_PH1:  seg_end = qnext >= lim1_n;
         default:  seg_end = qnext >= lim2_n;
      endcase
   end

   assign restart    = hard_go;
   assign sample_stb = tick && !hard_go && seg_end && (seg_q == SEG_PH1);
   assign tx_stb     = tick && !hard_go && seg_end && (seg_q == SEG_PH2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q     <= SEG_SYNC;
         qcnt_q    <= '0;
         lim1_q    <= QW'(1);
         lim2_q    <= QW'(2);
         rs_done_q <= 1'b0;
      end else if (hold || hard_go) begin
         seg_q     <= SEG_SYNC;
         qcnt_q    <= '0;
         rs_done_q <= hard_go;
      end else begin
         lim1_q <= lim1_n;
         lim2_q <= lim2_n;
         if (late_go || early_go) rs_done_q <= 1'b1;
         if (tick) begin
            if (seg_end) begin
               qcnt_q <= '0;
               unique case (seg_q)
                  SEG_SYNC: begin
                     seg_q  <= SEG_PROP;
                     lim1_q <= base1;
                     lim2_q <= base2;
                  end
                  SEG_PROP: seg_q <= SEG_PH1;
                  SEG_PH1:  seg_q <= SEG_PH2;
                  default: begin
                     seg_q     <= SEG_SYNC;
                     rs_done_q <= 1'b0;
                  end
               endcase
            end else begin
               qcnt_q <= qnext;
            end
         end
      end
   end

   assert_ext_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q != SEG_SYNC) |-> (lim1_q <= base1 + sjw_len));
   assert_shrink_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q == SEG_PH2) |-> (lim2_q + sjw_len >= base2));
   assert_one_resync_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q == SEG_PH2 && lim2_q != base2) |-> (lim1_q == base1));
   assert_hard_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hard_go |=> (seg_q == SEG_SYNC && qcnt_q == '0));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int PRESC_W     = 8,
   parameter int SEG_W       = 3,
   parameter int SJW_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CFG_W       = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             rx,
   input  logic             bus_idle,
   input  logic             busoff_evt,
   input  logic             err_evt,
   output logic             tq_tick,
   output logic             sample_stb,
   output logic             tx_stb,
   output logic             busoff_irq,
   output logic             err_irq
);
   localparam int USED_W = 3 * SEG_W + SJW_W + PRESC_W + 2;

   if (USED_W > CFG_W) begin : g_bad_cfg_w
      $error("configuration word too narrow for the fields");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("receive synchroniser needs at least two stages");
   end
   if (SJW_W > SEG_W) begin : g_bad_sjw
      $error("jump width field wider than a segment field");
   end

   logic [PRESC_W-1:0] presc;
   logic [SEG_W-1:0]   prop, ph1, ph2;
   logic [SJW_W-1:0]   sjw;
   logic               err_en, boff_en, restart;

   can_bt_cfg #(.PRESC_W(PRESC_W), .SEG_W(SEG_W), .SJW_W(SJW_W), .CFG_W(CFG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .wr_en(cfg_wr), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .presc(presc), .prop(prop), .ph1(ph1), .ph2(ph2), .sjw(sjw),
      .err_en(err_en), .boff_en(boff_en));

   can_bt_presc #(.PRESC_W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .hold(freeze), .restart(restart), .div(presc),
      .tick(tq_tick));

   can_bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W), .SYNC_STAGES(SYNC_STAGES)) u_seq (
      .clk(clk), .rst_n(rst_n), .hold(freeze), .tick(tq_tick), .rx(rx),
      .bus_idle(bus_idle), .prop(prop), .ph1(ph1), .ph2(ph2), .sjw(sjw),
      .restart(restart), .sample_stb(sample_stb), .tx_stb(tx_stb));

   assign busoff_irq = busoff_evt && boff_en;
   assign err_irq    = err_evt && err_en;

   assert_strobe_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb || tx_stb) |-> tq_tick);
   assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !tx_stb);
   assert_freeze_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> (!tq_tick && !sample_stb && !tx_stb));
endmodule

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freeze = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        rx = 1'b1;
   logic        bus_idle = 1'b0;
   logic        busoff_evt = 1'b0;
   logic        err_evt = 1'b0;
   logic        tq_tick, sample_stb, tx_stb, busoff_irq, err_irq;

   int n_cmp = 0;
   int n_bad = 0;
   int s_at[3];
   int t_at[3];
   int n_ticks;
   int quiet;

   always #5 clk = ~clk;

   can_bit_timer u_can_bit_timer (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .rx(rx), .bus_idle(bus_idle), .busoff_evt(busoff_evt),
      .err_evt(err_evt), .tq_tick(tq_tick), .sample_stb(sample_stb), .tx_stb(tx_stb),
      .busoff_irq(busoff_irq), .err_irq(err_irq));

   // columns: divider, prop, ph1, ph2, first sample, first tx, second tx, ticks in two bits
   localparam int VEC [0:4][0:7] = '{
      '{  0, 0, 0, 1,   2,    4,    9, 10},
      '{  0, 2, 3, 2,   7,   10,   21, 22},
      '{  3, 1, 2, 2,  23,   35,   71, 18},
      '{  1, 7, 7, 7,  33,   49,   99, 50},
      '{255, 0, 0, 1, 767, 1279, 2559, 10}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int dv, input int pr, input int p1, input int p2,
                     input int jw, input int boff, input int er);
      cfg_wdata = 32'(pr) | (32'(p1) << 3) | (32'(p2) << 6) | (32'(jw) << 9) |
                  (32'(dv) << 11) | (32'(er) << 19) | (32'(boff) << 20);
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Releases freeze at a falling clock edge and records strobe positions, counted
   // in clocks from the first unfrozen clock (k = 0).
   task automatic run_window(input int limit, input int f1, input int r1, input int f2,
                             input logic idle);
      int ns = 0;
      int nt = 0;
      for (int i = 0; i < 3; i++) begin s_at[i] = -1; t_at[i] = -1; end
      n_ticks  = 0;
      bus_idle = idle;
      freeze   = 1'b0;
      for (int k = 0; k <= limit; k++) begin
         #1;
         if (tq_tick && nt < 2) n_ticks++;
         if (sample_stb && ns < 3) begin s_at[ns] = k; ns++; end
         if (tx_stb && nt < 3) begin t_at[nt] = k; nt++; end
         if (k == f1) rx = 1'b0;
         if (k == r1) rx = 1'b1;
         if (k == f2) rx = 1'b0;
         @(negedge clk);
      end
      freeze   = 1'b1;
      rx       = 1'b1;
      bus_idle = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #1_500_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      busoff_evt = 1'b1;
      err_evt = 1'b1;
      @(negedge clk);
      #1;
      // R1: reset state
      chk("R1 readback", int'(cfg_rdata), 64);
      chk("R1 irq", int'({busoff_irq, err_irq}), 0);
      chk("R1 strobes", int'({tq_tick, sample_stb, tx_stb}), 0);

      // R2/R3/R4: vector table, one freeze release per row
      for (int v = 0; v < 5; v++) begin
         wr(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0, 0, 0);
         repeat (2) @(negedge clk);
         run_window(VEC[v][6] + 2, -1, -1, -1, 1'b0);
         chk($sformatf("R3/R4 row %0d first sample", v), s_at[0], VEC[v][4]);
         chk($sformatf("R3 row %0d first tx", v), t_at[0], VEC[v][5]);
         chk($sformatf("R3 row %0d second tx", v), t_at[1], VEC[v][6]);
         chk($sformatf("R2 row %0d tick count", v), n_ticks, VEC[v][7]);
      end

      // R4: nothing moves while frozen
      quiet = 0;
      for (int k = 0; k < 20; k++) begin
         #1;
         if (tq_tick || sample_stb || tx_stb) quiet++;
         @(negedge clk);
      end
      chk("R4 frozen activity", quiet, 0);

      // R6: phase-2 zero stored as one
      wr(0, 1, 2, 0, 1, 0, 0);
      #1;
      chk("R6 ph2 clamp", int'(cfg_rdata[8:6]), 1);

      // R5/R11: unfrozen write changes only the enable bits
      wr(0, 1, 2, 2, 1, 0, 0);
      freeze = 1'b0;
      wr(255, 7, 7, 7, 3, 1, 1);
      #1;
      chk("R5 timing fields locked", int'(cfg_rdata[18:0]), 1 | (2 << 3) | (2 << 6) | (1 << 9));
      chk("R11 enables written unfrozen", int'(cfg_rdata[20:19]), 3);
      chk("R11 irq pass", int'({busoff_irq, err_irq}), 3);
      busoff_evt = 1'b0;
      #1;
      chk("R11 busoff follows evt", int'({busoff_irq, err_irq}), 1);
      wr(0, 0, 0, 1, 0, 1, 0);
      #1;
      chk("R11 err masked", int'({busoff_irq, err_irq}), 0);
      freeze = 1'b1;
      @(negedge clk);

      // config for resync tests: N=9 (prop 2, ph1 3, ph2 3), jump width 2
      wr(0, 1, 2, 2, 1, 0, 0);
      run_window(30, -1, -1, -1, 1'b0);
      chk("R3 base second sample", s_at[1], 14);
      chk("R3 base second tx", t_at[1], 17);

      // R8: late edge at position 1 of bit 2
      run_window(30, 8, -1, -1, 1'b0);
      chk("R8 late sample", s_at[1], 15);
      chk("R8 late tx", t_at[1], 18);

      // R9: early edge with two phase-2 quanta left
      run_window(30, 14, -1, -1, 1'b0);
      chk("R9 sample unchanged", s_at[1], 14);
      chk("R9 early tx", t_at[1], 16);
      chk("R9 next bit tx", t_at[2], 25);

      // R10: second edge in same bit ignored
      run_window(30, 8, 9, 10, 1'b0);
      chk("R10 sample", s_at[1], 15);
      chk("R10 tx", t_at[1], 18);

      // R12: edge in sync quantum, then rising edge
      run_window(30, 7, 10, -1, 1'b0);
      chk("R12 sample", s_at[1], 14);
      chk("R12 tx", t_at[1], 17);
      chk("R12 third tx", t_at[2], 26);

      // R7: hard resync on idle bus
      run_window(30, 2, -1, -1, 1'b1);
      chk("R7 first sample", s_at[0], 10);
      chk("R7 first tx", t_at[0], 13);

      // R8: jump width 1 caps the stretch
      wr(0, 1, 2, 2, 0, 0, 0);
      run_window(30, 11, -1, -1, 1'b0);
      chk("R8 capped sample", s_at[1], 15);
      chk("R8 capped tx", t_at[1], 18);

      summary();
      $finish;
   end
endmodule